// File: doc/BRIEF.md
# Slow-Clock Monitor Reset Generator

This block watches a monitored bus clock from a free-running reference clock and raises a reset request when the monitored clock runs too slowly or stops. The monitored clock is treated as an asynchronous data signal. It passes through a synchronizer into the reference domain, and each rising edge that survives synchronization restarts a timeout counter. If the counter reaches its limit before the next edge arrives, the block latches a reset request. A separate reset sequencer consumes that request.

The timeout length is a parameter measured in reference cycles. Choose it so that the boundary period falls between the slowest clock that must always trip and the fastest clock that must never trip. With a 1 MHz reference, the default of 50 cycles puts the boundary at 20 kHz. That lies between a 10 kHz must-trip limit and a 200 kHz must-not-trip limit.

Monitoring runs when either the software enable or the force-enable input is high. A stop-mode indication halts the monitored clock. While it is high, any edges are disregarded. If monitoring is active when the clock stops, the block therefore trips on purpose. Software is expected to drop the enable before entering stop.

Top module: `clkmon_top`

## Requirements
- R1: While `rst` is high at a reference edge, `clk_fail_req` is low in the following cycle, and the timeout count returns to zero.
- R2: With monitoring active, a gap of more than TIMEOUT_CYC reference cycles between counter restarts makes `clk_fail_req` go high. A rising edge on `mon_clk` (low at one reference edge, high at the next) restarts the counter at the second reference edge after the high sample. The request goes high TIMEOUT_CYC+1 edges after the last restart.
- R3: A monitored clock whose period is at most TIMEOUT_CYC reference cycles never raises the request. This includes a period of exactly TIMEOUT_CYC.
- R4: Monitoring is active when `mon_en` or `force_en` is high. With `force_en` high and `mon_en` low, a halted clock still trips.
- R5: While both `mon_en` and `force_en` are low, the counter is held at zero and the request is not raised, whatever `mon_clk` does. After monitoring is re-enabled, the gap is counted afresh.
- R6: While `stop_mode` is high, rising edges on `mon_clk` do not restart the counter. An active monitor therefore trips after TIMEOUT_CYC+1 cycles in stop mode, even if `mon_clk` keeps toggling. With monitoring inactive, stop mode causes no request.
- R7: Once high, `clk_fail_req` stays high until `rst` is applied. This holds even if the clock recovers or monitoring is disabled.
- R8: A monitored clock stuck high trips exactly like one stuck low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst | input | 1 | Synchronous active-high reset of the block |
| mon_clk | input | 1 | Monitored clock, asynchronous to `clk` |
| mon_en | input | 1 | Software monitor enable (low after system reset) |
| force_en | input | 1 | Force-enable; monitoring runs regardless of `mon_en` |
| stop_mode | input | 1 | High while the monitored clock is halted for stop mode |
| clk_fail_req | output | 1 | Sticky reset request to the reset sequencer |

## Verification
The assertions assume three things about the inputs. `mon_en`, `force_en` and `stop_mode` are synchronous to the reference clock. `mon_clk` may change at any time, but the synchronizer leaves its sample indeterminate only within one reference cycle of a transition. The properties therefore speak about the counter and the request, never about the exact cycle a raw edge lands. The stimulus changes every input, including `mon_clk`, on the falling reference edge. This makes each sample well defined, so the cycle-by-cycle reference model can predict the exact trip cycle. Clock periods straddle the boundary at TIMEOUT_CYC and TIMEOUT_CYC+2 reference cycles, and stop mode is entered with the monitored clock still toggling.

// File: rtl/clkmon_pkg.sv
package clkmon_pkg;

    // Default gap, in reference cycles, tolerated between monitored edges.
    localparam int unsigned CM_TIMEOUT_DEF = 50;
    // Default synchronizer depth for the monitored clock.
    localparam int unsigned CM_SYNC_DEF    = 2;

    // Decoded control for the timer and request logic.
    typedef struct packed {
        logic active;    // monitoring is running
        logic edges_ok;  // monitored edges may restart the timer
    } cm_ctl_t;

    // Request tracker state.
    typedef enum logic [1:0] {
        CM_IDLE  = 2'd0,
        CM_COUNT = 2'd1,
        CM_TRIP  = 2'd2
    } cm_state_e;

    // Bits needed to hold values 0..v.
    function automatic int unsigned cm_bits(input int unsigned v);
        return (v < 2) ? 1 : $clog2(v + 1);
    endfunction

endpackage

// File: rtl/clkmon_edge_sync.sv
module clkmon_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              last_q;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[0] <= 1'b0;
                else     chain[0] <= async_in;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= 1'b0;
                else     chain[i] <= chain[i-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b0;
        else     last_q <= chain[STAGES-1];
    end

    assign rise = chain[STAGES-1] & ~last_q;
endmodule

// File: rtl/clkmon_ctl.sv
module clkmon_ctl
    import clkmon_pkg::*;
(
    input  logic    mon_en,
    input  logic    force_en,
    input  logic    stop_mode,
    output cm_ctl_t ctl
);
    always_comb begin
        ctl.active   = mon_en | force_en;
        ctl.edges_ok = ~stop_mode;
    end
endmodule

// File: rtl/clkmon_timer.sv
module clkmon_timer #(
    parameter int unsigned TIMEOUT_CYC = 50,
    parameter int unsigned CNT_W       = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic             restart,
    output logic [CNT_W-1:0] cnt,
    output logic             expired
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT_CYC);

    always_ff @(posedge clk) begin
        if (rst || !active)  cnt <= '0;
        else if (restart)    cnt <= '0;
        else if (cnt != LIMIT) cnt <= cnt + 1'b1;
    end

    assign expired = active && (cnt == LIMIT);
endmodule

// File: rtl/clkmon_req.sv
module clkmon_req
    import clkmon_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic expired,
    output logic req
);
    cm_state_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= CM_IDLE;
        end else begin
            unique case (state)
                CM_TRIP: state <= CM_TRIP;
                default: begin
                    if (expired)     state <= CM_TRIP;
                    else if (active) state <= CM_COUNT;
                    else             state <= CM_IDLE;
                end
            endcase
        end
    end

    assign req = (state == CM_TRIP);
endmodule

// File: rtl/clkmon_top.sv
module clkmon_top
    import clkmon_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYC = CM_TIMEOUT_DEF,
    parameter int unsigned SYNC_STAGES = CM_SYNC_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic mon_clk,
    input  logic mon_en,
    input  logic force_en,
    input  logic stop_mode,
    output logic clk_fail_req
);
    localparam int unsigned CNT_W = cm_bits(TIMEOUT_CYC);

    cm_ctl_t          ctl;
    logic             mon_active;
    logic             mon_rise;
    logic             tmr_restart;
    logic [CNT_W-1:0] tmr_cnt;
    logic             tmr_expired;

    clkmon_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (mon_clk),
        .rise     (mon_rise)
    );

    clkmon_ctl u_ctl (
        .mon_en    (mon_en),
        .force_en  (force_en),
        .stop_mode (stop_mode),
        .ctl       (ctl)
    );

    assign mon_active  = ctl.active;
    assign tmr_restart = mon_rise & ctl.edges_ok;

    clkmon_timer #(.TIMEOUT_CYC(TIMEOUT_CYC), .CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .active  (mon_active),
        .restart (tmr_restart),
        .cnt     (tmr_cnt),
        .expired (tmr_expired)
    );

    clkmon_req u_req (
        .clk     (clk),
        .rst     (rst),
        .active  (mon_active),
        .expired (tmr_expired),
        .req     (clk_fail_req)
    );
endmodule

// File: rtl/clkmon_chk.sv
module clkmon_chk #(
    parameter int unsigned TIMEOUT_CYC = 50,
    parameter int unsigned CNT_W       = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             mon_active,
    input logic             stop_mode,
    input logic [CNT_W-1:0] tmr_cnt,
    input logic             clk_fail_req
);
    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (!clk_fail_req && tmr_cnt == '0));

    // R7
    req_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        clk_fail_req |=> clk_fail_req);

    // R2
    trip_on_limit_chk: assert property (@(posedge clk) disable iff (rst)
        (mon_active && tmr_cnt == CNT_W'(TIMEOUT_CYC)) |=> clk_fail_req);

    // R5
    idle_no_trip_chk: assert property (@(posedge clk) disable iff (rst)
        (!mon_active && !clk_fail_req) |=> !clk_fail_req);

    // R5
    idle_count_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !mon_active |=> (tmr_cnt == '0));

    // R6
    stop_keeps_counting_chk: assert property (@(posedge clk) disable iff (rst)
        (mon_active && stop_mode && $past(mon_active) && $past(!rst)
         && tmr_cnt < CNT_W'(TIMEOUT_CYC))
        |=> (tmr_cnt == $past(tmr_cnt) + 1'b1));

    // R3
    count_bounded_chk: assert property (@(posedge clk) disable iff (rst)
        tmr_cnt <= CNT_W'(TIMEOUT_CYC));
endmodule

bind clkmon_top clkmon_chk #(.TIMEOUT_CYC(TIMEOUT_CYC), .CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .mon_active   (mon_active),
    .stop_mode    (stop_mode),
    .tmr_cnt      (tmr_cnt),
    .clk_fail_req (clk_fail_req)
);

// File: tb/tb_clkmon_top.sv
module tb_clkmon_top;
    localparam int T = 50;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mon_clk = 1'b0;
    logic mon_en = 1'b0;
    logic force_en = 1'b0;
    logic stop_mode = 1'b0;
    logic clk_fail_req;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    always #2.5 clk = ~clk;

    clkmon_top #(.TIMEOUT_CYC(T)) dut (
        .clk          (clk),
        .rst          (rst),
        .mon_clk      (mon_clk),
        .mon_en       (mon_en),
        .force_en     (force_en),
        .stop_mode    (stop_mode),
        .clk_fail_req (clk_fail_req)
    );

    // Behavioural reference: history of samples, gap counter, latched request.
    bit hist[$];
    int gap = 0;
    bit exp_req = 1'b0;

    always @(posedge clk) begin
        bit r;
        bit act;
        cycles++;
        if (rst) begin
            hist = '{0, 0, 0};
            gap = 0;
            exp_req = 0;
        end else begin
            r   = hist[hist.size()-2] && !hist[hist.size()-3];
            act = mon_en || force_en;
            if (act && gap == T) exp_req = 1;
            if (!act)                 gap = 0;
            else if (r && !stop_mode) gap = 0;
            else if (gap < T)         gap = gap + 1;
            hist.push_back(mon_clk);
            while (hist.size() > 4) void'(hist.pop_front());
        end
    end

    // Every-cycle comparison against the model (R2, R7 timing).
    always @(negedge clk) begin
        if (!rst) begin
            n_tests++;
            if (clk_fail_req !== exp_req) begin
                n_fail++;
                $display("FAIL R2/R7 model at cycle %0d: actual=%b expected=%b",
                         cycles, clk_fail_req, exp_req);
            end
        end
    end

    task automatic chk(input logic act, input logic expv, input string tag);
        n_tests++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, expv);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; mon_en = 0; force_en = 0; stop_mode = 0; mon_clk = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // Drive mon_clk for n reference cycles, toggling every 'half' cycles (0 = hold).
    task automatic run(input int n, input int half);
        int ph = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (half > 0) begin
                ph++;
                if (ph >= half) begin
                    mon_clk = ~mon_clk;
                    ph = 0;
                end
            end
        end
    endtask

    initial begin
        do_reset();
        @(negedge clk);
        chk(clk_fail_req, 1'b0, "R1 reset state");

        // R5: disabled, clock halted for long
        run(300, 0);
        chk(clk_fail_req, 1'b0, "R5 disabled halted clock");

        // R3: fast clock, then clock at exactly the boundary period
        mon_en = 1;
        run(600, 10);
        chk(clk_fail_req, 1'b0, "R3 period 20");
        run(600, 25);
        chk(clk_fail_req, 1'b0, "R3 period equal to timeout");

        // R2: period just above the boundary trips; R7 stays after recovery
        do_reset();
        mon_en = 1;
        run(400, 26);
        chk(clk_fail_req, 1'b1, "R2 period 52 trips");
        run(200, 5);
        chk(clk_fail_req, 1'b1, "R7 sticky after clock recovers");
        mon_en = 0;
        run(20, 5);
        chk(clk_fail_req, 1'b1, "R7 sticky after disable");

        // R2: stuck low after a fast clock
        do_reset();
        mon_en = 1;
        run(100, 5);
        mon_clk = 0;
        run(T - 5, 0);
        chk(clk_fail_req, 1'b0, "R2 not yet tripped");
        run(60, 0);
        chk(clk_fail_req, 1'b1, "R2 stuck low trips");

        // R8: stuck high
        do_reset();
        mon_en = 1;
        run(100, 5);
        mon_clk = 1;
        run(T + 10, 0);
        chk(clk_fail_req, 1'b1, "R8 stuck high trips");

        // R4: force-enable alone
        do_reset();
        force_en = 1;
        run(T + 10, 0);
        chk(clk_fail_req, 1'b1, "R4 force-enable trips");

        // R6: stop mode with monitor active, clock still toggling
        do_reset();
        mon_en = 1;
        run(60, 5);
        stop_mode = 1;
        run(T + 10, 5);
        chk(clk_fail_req, 1'b1, "R6 stop with monitor active trips");

        // R6/R5: stop mode with monitor off is harmless
        do_reset();
        stop_mode = 1;
        run(200, 0);
        chk(clk_fail_req, 1'b0, "R6 stop with monitor off");
        stop_mode = 0;
        mon_en = 1;
        run(200, 5);
        chk(clk_fail_req, 1'b0, "R6 wake and re-enable");

        // R5: disabling clears the gap count
        do_reset();
        mon_en = 1;
        run(40, 0);
        mon_en = 0;
        run(5, 0);
        mon_en = 1;
        run(40, 0);
        chk(clk_fail_req, 1'b0, "R5 count restarted after disable");
        run(20, 0);
        chk(clk_fail_req, 1'b1, "R5 later gap trips");

        do_reset();
        @(negedge clk);
        chk(clk_fail_req, 1'b0, "R1 reset clears request");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        n_fail++;
        $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule